// File: doc/BRIEF.md
# Four-Digit Decimal Arithmetic Unit

This block performs arithmetic on packed BCD words. Each operand holds `DIGITS` decimal digits, four in the default build. A caller places an operation code and two operands on the inputs and pulses `start` for one cycle. The unit then returns a result word and a second word, together with a carry flag and an error flag.

Addition and subtraction finish in one cycle. Both consume the carry flag as an incoming carry or borrow, and both update it. Multiplication and division run digit by digit over several cycles, and `busy` stays high while they run. Multiplication writes the low half of the double-width product to the result word and the high half to the second word. Division writes the quotient to the result word and the remainder to the second word. Two further operation codes set or clear the carry flag on their own, so a caller can prepare a chained add or subtract.

Any operand that contains a nibble above 9 is rejected, and so is a zero divisor. In both cases the unit raises the error flag and leaves the data words and the carry flag untouched.

Top module: `bcd_arith_unit`

## Requirements
- R1: Opcode 0 (add) gives result = (A + B + carry) mod 10^DIGITS and sets carry when A + B + carry exceeds 10^DIGITS - 1, else clears it; the second word becomes 0.
- R2: Opcode 1 (subtract) computes A - B - carry; a non-negative difference appears as is with carry cleared, a negative one as its ten's complement (10^DIGITS plus the difference) with carry set; the second word becomes 0.
- R3: Opcode 2 (multiply) writes the low DIGITS digits of A x B to the result word and the high DIGITS digits to the second word; carry is unchanged.
- R4: Opcode 3 (divide) writes the quotient of A / B to the result word and the remainder to the second word; carry is unchanged.
- R5: Opcode 4 sets carry and opcode 5 clears it; neither changes the data words, and both clear the error flag.
- R6: For opcodes 0 to 3, an operand with any nibble above 9 sets the error flag and leaves both data words and carry unchanged; every operation that completes without an error clears the error flag.
- R7: Division with B = 0 sets the error flag and leaves both data words and carry unchanged.
- R8: Opcodes 0, 1, 4 and 5, and any rejected operation, raise `done` in the cycle after the `start` cycle; `busy` stays low.
- R9: A valid multiply or divide holds `busy` high from the cycle after `start` until completion; `done` is a one-cycle pulse with `busy` low, and the data words and carry do not change while `busy` is high.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: After reset the result word, second word, carry, error, `busy` and `done` are all 0.
- R12: Opcodes 6 and 7 raise `done` in the next cycle and change no other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe |
| opcode | input | 3 | Operation code (0 add, 1 subtract, 2 multiply, 3 divide, 4 set carry, 5 clear carry) |
| opA | input | 4*DIGITS | Packed BCD operand A (addend, minuend, multiplicand, dividend) |
| opB | input | 4*DIGITS | Packed BCD operand B (addend, subtrahend, multiplier, divisor) |
| result | output | 4*DIGITS | Sum, difference, low product or quotient |
| resultHi | output | 4*DIGITS | High product or remainder; 0 after add or subtract |
| carry | output | 1 | Carry/borrow flag |
| error | output | 1 | Set by a rejected operand or a zero divisor |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with DIGITS = 2, which shrinks the operand space to 100 values per operand. At that size, addition can be swept over every operand pair. Subtraction, multiplication and division are each swept over every dividend or first operand, with a regular stride through the second operand. The add and subtract sweeps run back to back, so the carry left by one operation feeds the next, and both carry-in values occur many times. The two-digit width also keeps every multiply and divide short. The bench drives the corner cases directly: the largest product, bad nibbles in each operand, a zero divisor, starts issued while busy, and the reserved opcodes.

// File: rtl/bcd_arith_pkg.sv
package bcd_arith_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_SETC = 3'd4,
    OP_CLRC = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MSHIFT = 3'd1,
    ST_MADD   = 3'd2,
    ST_DSHIFT = 3'd3,
    ST_DSUB   = 3'd4
  } ctrlState_e;

  // Strobes from the sequencer to the datapath, valid for one cycle each
  typedef struct packed {
    logic loadOps;       // capture operands, clear accumulators
    logic mulShift;      // accumulator x10, fetch next multiplier digit
    logic mulAdd;        // accumulator += multiplicand
    logic divShift;      // bring down next dividend digit
    logic divSub;        // remainder -= divisor, quotient digit + 1
    logic commitAddSub;  // write single-cycle add/subtract result
    logic subMode;       // qualifies commitAddSub
    logic commitMul;     // publish product
    logic commitDiv;     // publish quotient and remainder
    logic commitCarry;   // write carryValue into carry flag
    logic carryValue;
    logic commitErr;     // reject operation
    logic commitNop;     // reserved opcode: done only
  } ctrlStrobes_t;

endpackage

// File: rtl/bcd_arith_dp.sv
module bcd_arith_dp
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  output logic [4*DIGITS-1:0] result,
  output logic [4*DIGITS-1:0] resultHi,
  output logic                carry,
  output logic                error,
  output logic                done,
  output logic                opsBad,
  output logic                divisorZero,
  output logic                mulCntZero,
  output logic                remGeDivisor
);

  localparam int W  = 4 * DIGITS;
  localparam int W2 = 2 * W;
  localparam int WR = W + 4;

  function automatic logic [W2:0] bcdAddWide(input logic [W2-1:0] x,
                                             input logic [W2-1:0] y,
                                             input logic          cin);
    logic [W2-1:0] sum;
    logic          c;
    logic [4:0]    s;
    c = cin;
    for (int i = 0; i < 2 * DIGITS; i++) begin
      s = 5'(x[4*i +: 4]) + 5'(y[4*i +: 4]) + 5'(c);
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      sum[4*i +: 4] = s[3:0];
    end
    return {c, sum};
  endfunction

  function automatic logic [W2-1:0] ninesComp(input logic [W2-1:0] x);
    logic [W2-1:0] r;
    for (int i = 0; i < 2 * DIGITS; i++) begin
      r[4*i +: 4] = 4'd9 - x[4*i +: 4];
    end
    return r;
  endfunction

  function automatic logic allDecimal(input logic [W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (x[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  logic [W-1:0]  regA;
  logic [W-1:0]  regB;
  logic [W2-1:0] acc;
  logic [3:0]    mulCnt;
  logic [WR-1:0] rem;
  logic [W-1:0]  quo;

  logic [W2-1:0] padA, padB, padRegA, padRegB, padRem;
  logic [W2:0]   addRes, subRes, accSum, remDiff;
  logic          addOvf, subNeg;
  logic          unusedBits;

  assign padA    = W2'(opA);
  assign padB    = W2'(opB);
  assign padRegA = W2'(regA);
  assign padRegB = W2'(regB);
  assign padRem  = W2'(rem);

  assign addRes  = bcdAddWide(padA, padB, carry);
  assign subRes  = bcdAddWide(padA, ninesComp(padB), ~carry);
  assign accSum  = bcdAddWide(acc, padRegA, 1'b0);
  assign remDiff = bcdAddWide(padRem, ninesComp(padRegB), 1'b1);

  assign addOvf = (addRes[W2-1:W] != '0);
  assign subNeg = ~subRes[W2];
  assign unusedBits = ^{addRes[W2], subRes[W2-1:W], accSum[W2], remDiff[W2:WR]};

  assign opsBad       = !(allDecimal(opA) && allDecimal(opB));
  assign divisorZero  = (opB == '0);
  assign mulCntZero   = (mulCnt == 4'd0);
  assign remGeDivisor = (rem >= WR'(regB));

  // Working registers for the sequential operations
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA   <= '0;
      regB   <= '0;
      acc    <= '0;
      mulCnt <= '0;
      rem    <= '0;
      quo    <= '0;
    end else if (strobes.loadOps) begin
      regA   <= opA;
      regB   <= opB;
      acc    <= '0;
      mulCnt <= '0;
      rem    <= '0;
      quo    <= '0;
    end else if (strobes.mulShift) begin
      acc    <= acc << 4;
      mulCnt <= regB[W-1 -: 4];
      regB   <= regB << 4;
    end else if (strobes.mulAdd) begin
      acc    <= accSum[W2-1:0];
      mulCnt <= mulCnt - 4'd1;
    end else if (strobes.divShift) begin
      rem    <= {rem[W-1:0], regA[W-1 -: 4]};
      regA   <= regA << 4;
      quo    <= quo << 4;
    end else if (strobes.divSub) begin
      rem    <= remDiff[WR-1:0];
      quo    <= quo + W'(1);
    end
  end

  // Architectural outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resultHi <= '0;
      carry    <= 1'b0;
      error    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= strobes.commitAddSub | strobes.commitMul | strobes.commitDiv |
              strobes.commitCarry | strobes.commitErr | strobes.commitNop;
      if (strobes.commitErr) begin
        error <= 1'b1;
      end else if (strobes.commitAddSub) begin
        error    <= 1'b0;
        resultHi <= '0;
        if (strobes.subMode) begin
          result <= subRes[W-1:0];
          carry  <= subNeg;
        end else begin
          result <= addRes[W-1:0];
          carry  <= addOvf;
        end
      end else if (strobes.commitMul) begin
        error    <= 1'b0;
        result   <= acc[W-1:0];
        resultHi <= acc[W2-1:W];
      end else if (strobes.commitDiv) begin
        error    <= 1'b0;
        result   <= quo;
        resultHi <= rem[W-1:0];
      end else if (strobes.commitCarry) begin
        error <= 1'b0;
        carry <= strobes.carryValue;
      end
    end
  end

endmodule

// File: rtl/bcd_arith_ctrl.sv
module bcd_arith_ctrl
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   opcode,
  input  logic         opsBad,
  input  logic         divisorZero,
  input  logic         mulCntZero,
  input  logic         remGeDivisor,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  localparam int SW = $clog2(DIGITS) + 1;

  ctrlState_e     state, stateNext;
  logic [SW-1:0]  stepCnt, stepNext;
  logic           lastStep;
  opcode_e        op;

  assign op       = opcode_e'(opcode);
  assign lastStep = (stepCnt == SW'(DIGITS - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobes   = '0;
    stateNext = state;
    stepNext  = stepCnt;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stepNext = '0;
          case (op)
            OP_ADD, OP_SUB: begin
              if (opsBad) strobes.commitErr = 1'b1;
              else begin
                strobes.commitAddSub = 1'b1;
                strobes.subMode      = (op == OP_SUB);
              end
            end
            OP_MUL: begin
              if (opsBad) strobes.commitErr = 1'b1;
              else begin
                strobes.loadOps = 1'b1;
                stateNext       = ST_MSHIFT;
              end
            end
            OP_DIV: begin
              if (opsBad || divisorZero) strobes.commitErr = 1'b1;
              else begin
                strobes.loadOps = 1'b1;
                stateNext       = ST_DSHIFT;
              end
            end
            OP_SETC: begin
              strobes.commitCarry = 1'b1;
              strobes.carryValue  = 1'b1;
            end
            OP_CLRC: strobes.commitCarry = 1'b1;
            default: strobes.commitNop = 1'b1;
          endcase
        end
      end
      ST_MSHIFT: begin
        strobes.mulShift = 1'b1;
        stateNext        = ST_MADD;
      end
      ST_MADD: begin
        if (!mulCntZero) strobes.mulAdd = 1'b1;
        else if (lastStep) begin
          strobes.commitMul = 1'b1;
          stateNext         = ST_IDLE;
        end else begin
          stepNext  = stepCnt + SW'(1);
          stateNext = ST_MSHIFT;
        end
      end
      ST_DSHIFT: begin
        strobes.divShift = 1'b1;
        stateNext        = ST_DSUB;
      end
      ST_DSUB: begin
        if (remGeDivisor) strobes.divSub = 1'b1;
        else if (lastStep) begin
          strobes.commitDiv = 1'b1;
          stateNext         = ST_IDLE;
        end else begin
          stepNext  = stepCnt + SW'(1);
          stateNext = ST_DSHIFT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepNext;
    end
  end

endmodule

// File: rtl/bcd_arith_unit.sv
module bcd_arith_unit
  import bcd_arith_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [2:0]          opcode,
  input  logic [4*DIGITS-1:0] opA,
  input  logic [4*DIGITS-1:0] opB,
  output logic [4*DIGITS-1:0] result,
  output logic [4*DIGITS-1:0] resultHi,
  output logic                carry,
  output logic                error,
  output logic                busy,
  output logic                done
);

  ctrlStrobes_t strobes;
  logic opsBad, divisorZero, mulCntZero, remGeDivisor;

  bcd_arith_ctrl #(.DIGITS(DIGITS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .opcode       (opcode),
    .opsBad       (opsBad),
    .divisorZero  (divisorZero),
    .mulCntZero   (mulCntZero),
    .remGeDivisor (remGeDivisor),
    .strobes      (strobes),
    .busy         (busy)
  );

  bcd_arith_dp #(.DIGITS(DIGITS)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .opA          (opA),
    .opB          (opB),
    .result       (result),
    .resultHi     (resultHi),
    .carry        (carry),
    .error        (error),
    .done         (done),
    .opsBad       (opsBad),
    .divisorZero  (divisorZero),
    .mulCntZero   (mulCntZero),
    .remGeDivisor (remGeDivisor)
  );

endmodule

// File: rtl/bcd_arith_unit_chk.sv
module bcd_arith_unit_chk #(
  parameter int DIGITS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [2:0]          opcode,
  input logic [4*DIGITS-1:0] result,
  input logic [4*DIGITS-1:0] resultHi,
  input logic                carry,
  input logic                error,
  input logic                busy,
  input logic                done
);

  function automatic logic wordDecimal(input logic [4*DIGITS-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (x[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  logic fastOp;
  assign fastOp = start && !busy &&
                  (opcode == 3'd0 || opcode == 3'd1 || opcode == 3'd4 || opcode == 3'd5);

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R9

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($stable(result) && $stable(resultHi) && $stable(carry)));  // R9

  AST_ERROR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> ($stable(result) && $stable(resultHi) && $stable(carry)));  // R6

  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rstN)
    fastOp |=> (done && !busy));  // R8

  AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode == 3'd4) |=> (carry && !error));  // R5

  AST_CLEAR_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode == 3'd5) |=> (!carry && !error));  // R5

  AST_WORDS_DECIMAL: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error) |-> (wordDecimal(result) && wordDecimal(resultHi)));  // R1

endmodule

bind bcd_arith_unit bcd_arith_unit_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .opcode   (opcode),
  .result   (result),
  .resultHi (resultHi),
  .carry    (carry),
  .error    (error),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_bcd_arith_unit.sv
module test_bcd_arith_unit;

  localparam int DG  = 2;
  localparam int W   = 4 * DG;
  localparam int MOD = 100;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   opcode = '0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] result, resultHi;
  logic         carry, error, busy, done;

  int checks = 0;
  int errors = 0;

  // Reference state tracked by the bench
  logic [W-1:0] mRes = '0;
  logic [W-1:0] mHi  = '0;
  logic         mCarry = 1'b0;
  logic         mErr = 1'b0;

  always #5 clk = ~clk;

  bcd_arith_unit #(.DIGITS(DG)) i_bcd_arith_unit (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .opA(opA), .opB(opB), .result(result), .resultHi(resultHi),
    .carry(carry), .error(error), .busy(busy), .done(done)
  );

  function automatic logic [W-1:0] toBcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < DG; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    checks++;
    if (result !== mRes || resultHi !== mHi || carry !== mCarry || error !== mErr) begin
      errors++;
      $display("FAIL %s: got res=%h hi=%h c=%0b e=%0b expected res=%h hi=%h c=%0b e=%0b",
               req, result, resultHi, carry, error, mRes, mHi, mCarry, mErr);
    end
  endtask

  // Issue one operation and wait for its done pulse (sampled at negedges)
  task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    int n;
    @(negedge clk);
    start = 1'b1; opcode = op; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    checkState("R11");
    checkBit("R11 busy", busy, 1'b0);
    checkBit("R11 done", done, 1'b0);

    // R5 set and clear carry
    issue(3'd4, 8'h55, 8'h66);
    mCarry = 1'b1;
    checkState("R5 set");
    issue(3'd5, 8'h55, 8'h66);
    mCarry = 1'b0;
    checkState("R5 clear");

    // R8 timing of a single-cycle add
    @(negedge clk);
    start = 1'b1; opcode = 3'd0; opA = 8'h12; opB = 8'h34;
    @(negedge clk);
    start = 1'b0;
    checkBit("R8 done", done, 1'b1);
    checkBit("R8 busy", busy, 1'b0);
    mRes = 8'h46; mHi = '0;
    checkState("R8 result");

    // R1 add sweep; carry chains from one add to the next
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b++) begin
        int s;
        issue(3'd0, toBcd(a), toBcd(b));
        s = a + b + int'(mCarry);
        mCarry = (s >= MOD);
        mRes = toBcd(s % MOD); mHi = '0; mErr = 1'b0;
        checkState("R1");
      end
    end

    // R2 subtract sweep
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b += 3) begin
        int d;
        issue(3'd1, toBcd(a), toBcd(b));
        d = a - b - int'(mCarry);
        mCarry = (d < 0);
        mRes = toBcd(d < 0 ? d + MOD : d); mHi = '0; mErr = 1'b0;
        checkState("R2");
      end
    end

    // R3 multiply sweep, run with carry set to see it preserved
    issue(3'd4, '0, '0);
    mCarry = 1'b1;
    for (int a = 0; a < MOD; a++) begin
      for (int b = 0; b < MOD; b += 7) begin
        issue(3'd2, toBcd(a), toBcd(b));
        mRes = toBcd((a * b) % MOD); mHi = toBcd((a * b) / MOD); mErr = 1'b0;
        checkState("R3");
      end
    end
    issue(3'd2, 8'h99, 8'h99);
    mRes = 8'h01; mHi = 8'h98;
    checkState("R3 max");

    // R4 divide sweep with carry clear
    issue(3'd5, '0, '0);
    mCarry = 1'b0;
    for (int a = 0; a < MOD; a++) begin
      for (int b = 1; b < MOD; b += 7) begin
        issue(3'd3, toBcd(a), toBcd(b));
        mRes = toBcd(a / b); mHi = toBcd(a % b); mErr = 1'b0;
        checkState("R4");
      end
    end
    issue(3'd3, 8'h99, 8'h01);
    mRes = 8'h99; mHi = 8'h00;
    checkState("R4 unit divisor");

    // R6 bad nibbles in each operand for several opcodes
    issue(3'd4, '0, '0);
    mCarry = 1'b1;
    checkState("R5 set again");
    issue(3'd0, 8'h3A, 8'h11);
    mErr = 1'b1;
    checkState("R6 add bad A");
    issue(3'd2, 8'h12, 8'hF0);
    checkState("R6 mul bad B");
    issue(3'd1, 8'hB0, 8'h00);
    checkState("R6 sub bad A");
    issue(3'd3, 8'h50, 8'h0C);
    checkState("R6 div bad B");
    issue(3'd0, 8'h10, 8'h20);
    mRes = 8'h31; mHi = '0; mCarry = 1'b0; mErr = 1'b0;
    checkState("R6 error cleared");

    // R7 divide by zero
    issue(3'd3, 8'h77, 8'h00);
    mErr = 1'b1;
    checkState("R7");

    // R12 reserved opcodes change nothing
    issue(3'd6, 8'h11, 8'h22);
    checkState("R12 op6");
    issue(3'd7, 8'h33, 8'h44);
    checkState("R12 op7");

    // R9 and R10: start held high during a multiply
    @(negedge clk);
    start = 1'b1; opcode = 3'd2; opA = 8'h99; opB = 8'h99;
    @(negedge clk);
    checkBit("R9 busy", busy, 1'b1);
    opcode = 3'd0; opA = 8'h01; opB = 8'h01;
    repeat (4) @(negedge clk);
    checkBit("R9 still busy", busy, 1'b1);
    start = 1'b0;
    begin
      int n = 0;
      while (!done && n < 200) begin
        @(negedge clk);
        n++;
      end
    end
    checkBit("R9 done", done, 1'b1);
    checkBit("R9 busy low", busy, 1'b0);
    mRes = 8'h01; mHi = 8'h98; mErr = 1'b0;
    checkState("R10");
    @(negedge clk);
    checkBit("R9 done pulse", done, 1'b0);
    checkState("R10 no late start");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule